// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Binary Counter

This block is a small synchronous up-counter. Every change of its state happens on the rising clock edge. A clear input forces the count to zero and has the highest priority. A load input copies a parallel data word into the count and comes next. Two count-enable inputs must both be high for the count to advance by one, and the count wraps from its all-ones value back to zero. When any of these conditions is absent, the count holds.

A carry-out signal is high when the count is all ones and the second count enable (the carry enable) is high. The carry-out is a combinational function of the registered count and that enable, so it follows the enable within the same cycle. Identical stages can therefore be chained: each stage's carry-out drives the next stage's carry enable, and the first enable is shared by all stages. The chain then behaves as one wide binary counter.

A decode of the count that drives the clear input gives a shorter modulus, because the clear acts on the following edge. The width defaults to four bits.

Top module: `sync_preset_counter`

## Requirements
- R1: When clearN is low at a rising edge, count becomes 0 after that edge, whatever the levels on loadN, enableCount, enableCarry and loadData.
- R2: When clearN is high and loadN is low at a rising edge, count takes the value of loadData, whatever the levels on enableCount and enableCarry.
- R3: When clearN, loadN, enableCount and enableCarry are all high at a rising edge, count increases by one.
- R4: When clearN and loadN are high and either enableCount or enableCarry is low at a rising edge, count keeps its value.
- R5: An increment from the all-ones value (15 for four bits) gives 0.
- R6: carryOut is 1 exactly when enableCarry is 1 and count is all ones. It responds to enableCarry within the same cycle, with no clock edge in between.
- R7: count bit 0 is the least significant bit, and loadData bit i loads count bit i.
- R8: Three stages, each with its carryOut driving the next stage's enableCarry and with enableCount, clearN and loadN shared, count as one 12-bit binary counter. Stage 0 holds the low four bits.
- R9: When clearN is driven low by a decode of count equal to 9 with both enables high, the count sequence is 0, 1, ..., 9, 0, a modulus of 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous parallel load, active low |
| enableCount | input | 1 | Count enable, active high |
| enableCarry | input | 1 | Count enable that also gates carryOut, active high |
| loadData | input | WIDTH | Parallel load value |
| count | output | WIDTH | Registered count value |
| carryOut | output | 1 | Terminal-count flag gated by enableCarry |

## Verification
A corrupted count register shows up at count on the next sampling point after the edge that wrote it. If the corrupted value is all ones, or should have been all ones, it also shows up at carryOut within the same cycle whenever enableCarry is high. A wrong priority among clear, load and advance gives a wrong count one edge after the conflicting controls. Every combination of the four control inputs is applied from several starting values to expose this. A fault in the carry path is visible in a single stage only in the cycles when the count is all ones. In the three-stage chain the same fault gives a wrong upper stage after one low-stage wrap, within 16 cycles.

// File: rtl/sync_counter_pkg.sv
package sync_counter_pkg;

  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
    logic carryGate;
  } ctrlStrobe_t;

endpackage

// File: rtl/counter_ctrl.sv
module counter_ctrl
  import sync_counter_pkg::*;
(
  input  logic        clk,
  input  logic        clearN,
  input  logic        loadN,
  input  logic        enableCount,
  input  logic        enableCarry,
  output ctrlStrobe_t strobe
);

  // priority: clear over load over advance
  always_comb begin
    strobe           = '0;
    strobe.carryGate = enableCarry;
    if (!clearN)
      strobe.clear = 1'b1;
    else if (!loadN)
      strobe.load = 1'b1;
    else if (enableCount && enableCarry)
      strobe.advance = 1'b1;
  end

  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  // R2: a held load never produces an advance strobe
  assert_load_blocks_advance_R2: assert property (@(posedge clk) disable iff (!seenEdge)
    !loadN |-> !strobe.advance);

  // R1: clear excludes the other strobes
  assert_clear_exclusive_R1: assert property (@(posedge clk) disable iff (!seenEdge)
    !clearN |-> (!strobe.load && !strobe.advance));

endmodule

// File: rtl/counter_datapath.sv
module counter_datapath
  import sync_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] carryIn;
  logic [WIDTH-1:0] incremented;
  logic [WIDTH-1:0] nextCount;
  logic             atMax;

  // look-ahead carry: each bit toggles when all lower bits are one
  assign carryIn[0] = 1'b1;
  for (genvar b = 1; b < WIDTH; b++) begin : g_lookahead
    assign carryIn[b] = carryIn[b-1] & count[b-1];
  end

  assign incremented = count ^ carryIn;
  assign atMax       = carryIn[WIDTH-1] & count[WIDTH-1];

  always_comb begin
    nextCount = count;
    if (strobe.clear)
      nextCount = ZERO;
    else if (strobe.load)
      nextCount = loadData;
    else if (strobe.advance)
      nextCount = incremented;
  end

  always_ff @(posedge clk) count <= nextCount;

  assign carryOut = strobe.carryGate & atMax;

  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  // R5: advancing from all ones lands on zero
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!seenEdge)
    ($past(strobe.advance) && ($past(count) == {WIDTH{1'b1}})) |-> (count == ZERO));

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import sync_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             enableCount,
  input  logic             enableCarry,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  ctrlStrobe_t strobe;

  counter_ctrl u_ctrl (
    .clk         (clk),
    .clearN      (clearN),
    .loadN       (loadN),
    .enableCount (enableCount),
    .enableCarry (enableCarry),
    .strobe      (strobe)
  );

  counter_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk      (clk),
    .strobe   (strobe),
    .loadData (loadData),
    .count    (count),
    .carryOut (carryOut)
  );

  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!seenEdge)
    !$past(clearN) |-> (count == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!seenEdge)
    ($past(clearN) && !$past(loadN)) |-> (count == $past(loadData)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!seenEdge)
    ($past(clearN) && $past(loadN) && $past(enableCount) && $past(enableCarry))
      |-> (count == WIDTH'($past(count) + 1'b1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!seenEdge)
    ($past(clearN) && $past(loadN) && !($past(enableCount) && $past(enableCarry)))
      |-> $stable(count));

  assert_carry_gate_R6: assert property (@(posedge clk) disable iff (!seenEdge)
    carryOut |-> (enableCarry && (count == {WIDTH{1'b1}})));

endmodule

// File: tb/sim_sync_preset_counter.sv
module sim_sync_preset_counter;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W      = 4;
  localparam int STAGES = 3;
  localparam int CW     = W * STAGES;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int applied = 0;
  int failed  = 0;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    applied++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // ---------------- single stage ----------------
  logic         clrN = 1'b1, ldN = 1'b1, enP = 1'b0, enT = 1'b0;
  logic [W-1:0] dat = '0;
  logic [W-1:0] q;
  logic         tc;

  sync_preset_counter #(.WIDTH(W)) u0 (
    .clk(clk), .clearN(clrN), .loadN(ldN), .enableCount(enP), .enableCarry(enT),
    .loadData(dat), .count(q), .carryOut(tc)
  );

  int    refQ     = 0;
  bit    refKnown = 0;
  string lastTag  = "R1";

  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [W-1:0] d, input string tagOverride = "");
    @(negedge clk);
    if (refKnown) check(lastTag, 16'(q), 16'(refQ));
    clrN = c; ldN = l; enP = p; enT = t; dat = d;
    #1;
    if (refKnown) check("R6", 16'(tc), 16'(t && refQ == 15));
    @(posedge clk);
    if (!c) begin refQ = 0; lastTag = "R1"; end
    else if (!l) begin refQ = int'(d); lastTag = "R2"; end
    else if (p && t) begin lastTag = (refQ == 15) ? "R5" : "R3"; refQ = (refQ + 1) % 16; end
    else lastTag = "R4";
    if (tagOverride != "") lastTag = tagOverride;
    refKnown = 1;
  endtask

  task automatic settle();
    @(negedge clk);
    check(lastTag, 16'(q), 16'(refQ));
  endtask

  // ---------------- modulus-10 by decode ----------------
  logic         mClr = 1'b1;
  logic [W-1:0] mq;
  logic         mtc;
  logic         mClearN;
  assign mClearN = mClr & (mq != 4'd9);

  sync_preset_counter #(.WIDTH(W)) u_mod (
    .clk(clk), .clearN(mClearN), .loadN(1'b1), .enableCount(1'b1), .enableCarry(1'b1),
    .loadData('0), .count(mq), .carryOut(mtc)
  );

  // ---------------- three-stage cascade ----------------
  logic          cClrN = 1'b1, cLdN = 1'b1, cEn = 1'b0;
  logic [CW-1:0] cDat = '0;
  logic [W-1:0]  cq  [STAGES];
  logic          ctc [STAGES];
  logic [STAGES-1:0] cEnT;
  logic [CW-1:0] cValue;

  assign cEnT[0] = cEn;
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g > 0) begin : g_link
      assign cEnT[g] = ctc[g-1];
    end
    sync_preset_counter #(.WIDTH(W)) u_stage (
      .clk(clk), .clearN(cClrN), .loadN(cLdN), .enableCount(cEn), .enableCarry(cEnT[g]),
      .loadData(cDat[g*W +: W]), .count(cq[g]), .carryOut(ctc[g])
    );
    assign cValue[g*W +: W] = cq[g];
  end

  int refC      = 0;
  bit refCKnown = 0;

  task automatic castStep(input logic c, input logic l, input logic e, input logic [CW-1:0] d);
    @(negedge clk);
    if (refCKnown) check("R8", 16'(cValue), 16'(refC));
    cClrN = c; cLdN = l; cEn = e; cDat = d;
    @(posedge clk);
    if (!c) refC = 0;
    else if (!l) refC = int'(d);
    else if (e) refC = (refC + 1) % (1 << CW);
    refCKnown = 1;
  endtask

  // ---------------- watchdog ----------------
  bit finished = 0;
  initial begin
    #(8 * 200000);
    if (!finished) begin
      failed++;
      applied++;
      $display("FAIL R8: watchdog got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int starts[4] = '{0, 7, 14, 15};

    // reset state through clear (R1)
    step(1'b0, 1'b1, 1'b1, 1'b1, 4'h5);
    settle();

    // every control combination from several start values (R1..R6)
    foreach (starts[s]) begin
      for (int combo = 0; combo < 16; combo++) begin
        step(1'b1, 1'b0, 1'b0, 1'b0, W'(starts[s]));
        step(combo[3], combo[2], combo[1], combo[0], W'(combo) ^ 4'hA);
      end
    end

    // reference sequence: clear, load 12, count through the wrap, inhibit (R5)
    step(1'b0, 1'b0, 1'b0, 1'b0, 4'h3);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd12);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 4'h0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 4'h0);

    // bit mapping with one-hot loads (R7)
    for (int i = 0; i < W; i++) step(1'b1, 1'b0, 1'b1, 1'b1, W'(1 << i), "R7");
    step(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, "R7");
    settle();

    // shortened modulus by decoding 9 into the clear (R9)
    @(negedge clk);
    mClr = 1'b0;
    @(negedge clk);
    mClr = 1'b1;
    check("R9", 16'(mq), 16'd0);
    for (int k = 1; k < 26; k++) begin
      @(negedge clk);
      check("R9", 16'(mq), 16'(k % 10));
    end

    // three-stage cascade as a 12-bit counter (R8)
    castStep(1'b0, 1'b1, 1'b0, '0);
    castStep(1'b1, 1'b0, 1'b0, 12'hFF0);
    for (int k = 0; k < 40; k++) castStep(1'b1, 1'b1, 1'b1, '0);
    castStep(1'b1, 1'b0, 1'b1, 12'h0F8);
    for (int k = 0; k < 20; k++) castStep(1'b1, 1'b1, (k % 5) != 2, '0);
    castStep(1'b0, 1'b1, 1'b1, '0);
    for (int k = 0; k < 300; k++) castStep(1'b1, 1'b1, 1'b1, '0);
    @(negedge clk);
    check("R8", 16'(cValue), 16'(refC));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

endmodule